// File: doc/BRIEF.md
# Miss-Tolerant Block Fetch Sequencer

This block sits between a branch predictor and an instruction cache and decides which basic-block address is fetched in each cycle. The predictor hands it a stream of predicted block addresses, and it does not need anything from the fetched contents to get the next one. The sequencer labels each new block with an increasing sequence tag and sends one fetch request per cycle to the cache. The cache answers hit or miss in the same cycle it accepts the request.

A block that hits is placed in a one-entry output register together with its tag. A block that misses does not stop fetch. It is parked in a small table of pending misses, and the next predicted block is fetched behind it. When the cache reports that a line has been filled, every parked block on that line becomes eligible for replay. Replays win over new blocks. Because of this, blocks reach the output out of program order, and a downstream consumer uses the tags to put them back in order. A flush empties the table, drops the output, and restarts fetch at a redirect address.

Top module: `blkfetch_seq`

## Requirements
- R1: After reset the output is empty (out_valid low), no request is presented while pred_valid is low, and no block is parked.
- R2: Each new block accepted by the cache takes the next tag. Tags start at 0 after reset and step by one for every accepted predicted or redirect block. pred_ready is high only in a cycle where the cache accepts that predicted address.
- R3: An accepted request that hits appears on out_addr/out_tag with out_valid in the following cycle. The output holds steady while out_ready is low. While the output is full and not draining, no request is presented.
- R4: An accepted request that misses produces no output. Its address and tag are parked, and the next predicted block is requested in the following cycle.
- R5: A fill whose fill_line equals address bits [AW-1:LINE_LSB] of a parked block makes that block ready. A ready block is requested with its original address and tag, ahead of any predicted or redirect block.
- R6: A miss whose line equals the fill_line presented in the same cycle is parked already ready. It is replayed without any further fill.
- R7: A replayed block that misses again goes back to waiting and needs a new fill.
- R8: Parked blocks take the lowest free table slot. When several blocks are ready, the one in the lowest slot is replayed first.
- R9: With all DEPTH slots occupied, no new predicted block is accepted. Replays still issue, and acceptance resumes once a replay hits.
- R10: During a flush cycle no request is presented and pred_ready is low. The flush clears all parked blocks and the output. The next request is the redirect address with the next tag, ahead of the predictor.
- R11: While req_ready is low, no block is accepted, no tag is consumed and nothing is parked or freed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_valid | input | 1 | Predicted block address available |
| pred_addr | input | AW | Predicted block address |
| pred_ready | output | 1 | Predicted address consumed this cycle |
| flush | input | 1 | Discard pending work and redirect |
| flush_addr | input | AW | Redirect address used with flush |
| req_valid | output | 1 | Fetch request to the cache |
| req_ready | input | 1 | Cache accepts the request |
| req_addr | output | AW | Requested block address |
| req_tag | output | TW | Sequence tag of the requested block |
| req_hit | input | 1 | Hit (1) or miss (0) for the accepted request |
| fill_valid | input | 1 | A missed line has been filled |
| fill_line | input | AW-LINE_LSB | Line number of the filled line |
| out_valid | output | 1 | Fetched block available |
| out_ready | input | 1 | Consumer takes the block |
| out_addr | output | AW | Address of the delivered block |
| out_tag | output | TW | Sequence tag of the delivered block |

## Verification
Parking a miss and returning a fill can happen in the same cycle for the same line. In that case the new entry would never see a later fill and would wait forever. The bench provokes this by driving a predicted block that misses while fill_line names that block's line. It then expects that block, with its original tag, to be requested in the very next cycle ahead of the pending prediction and without a second fill. The same pairing is also tried with a replayed block that misses in the cycle after a fill, which must wait for a fresh fill.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    typedef enum logic [1:0] {
        ENT_FREE  = 2'd0,
        ENT_WAIT  = 2'd1,
        ENT_READY = 2'd2
    } ent_st_e;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_REPLAY = 2'd1,
        SRC_REDIR  = 2'd2,
        SRC_PRED   = 2'd3
    } src_e;

endpackage

// File: rtl/fseq_pend_table.sv
module fseq_pend_table
    import fseq_pkg::*;
#(
    parameter int DEPTH    = 4,
    parameter int AW       = 16,
    parameter int TW       = 8,
    parameter int LINE_LSB = 4,
    localparam int LW      = AW - LINE_LSB,
    localparam int IW      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          alloc_en,
    input  logic [AW-1:0] alloc_addr,
    input  logic [TW-1:0] alloc_tag,
    input  logic          take_en,
    input  logic          take_hit,
    input  logic          fill_en,
    input  logic [LW-1:0] fill_line,
    output logic          rep_valid,
    output logic [AW-1:0] rep_addr,
    output logic [TW-1:0] rep_tag,
    output logic          full
);

    typedef struct packed {
        ent_st_e       st;
        logic [AW-1:0] addr;
        logic [TW-1:0] tag;
    } ent_t;

    ent_t [DEPTH-1:0] ent_q, ent_d;

    logic [DEPTH-1:0] free_v;
    logic [DEPTH-1:0] rdy_v;
    logic [DEPTH-1:0] fill_hit_v;
    logic [IW-1:0]    free_idx;
    logic [IW-1:0]    rdy_idx;
    logic             alloc_hot;
    logic             take_hot;

    // per-slot status and fill compare
    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_slot
            assign free_v[g]     = (ent_q[g].st == ENT_FREE);
            assign rdy_v[g]      = (ent_q[g].st == ENT_READY);
            assign fill_hit_v[g] = fill_en && (ent_q[g].st == ENT_WAIT)
                                   && (ent_q[g].addr[AW-1:LINE_LSB] == fill_line);
        end
    endgenerate

    // lowest-index pick for allocation and replay
    always_comb begin
        free_idx = '0;
        rdy_idx  = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (free_v[i]) free_idx = IW'(i);
            if (rdy_v[i])  rdy_idx  = IW'(i);
        end
    end

    assign alloc_hot = fill_en && (alloc_addr[AW-1:LINE_LSB] == fill_line);
    assign take_hot  = fill_en && (ent_q[rdy_idx].addr[AW-1:LINE_LSB] == fill_line);

    always_comb begin
        ent_d = ent_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (fill_hit_v[i]) ent_d[i].st = ENT_READY;
        end
        if (take_en) begin
            if (take_hit)      ent_d[rdy_idx].st = ENT_FREE;
            else if (take_hot) ent_d[rdy_idx].st = ENT_READY;
            else               ent_d[rdy_idx].st = ENT_WAIT;
        end
        if (alloc_en) begin
            ent_d[free_idx].st   = alloc_hot ? ENT_READY : ENT_WAIT;
            ent_d[free_idx].addr = alloc_addr;
            ent_d[free_idx].tag  = alloc_tag;
        end
        if (clr) begin
            for (int i = 0; i < DEPTH; i++) ent_d[i].st = ENT_FREE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    assign rep_valid = |rdy_v;
    assign rep_addr  = ent_q[rdy_idx].addr;
    assign rep_tag   = ent_q[rdy_idx].tag;
    assign full      = ~|free_v;

endmodule

// File: rtl/fseq_src_arb.sv
module fseq_src_arb
    import fseq_pkg::*;
(
    input  logic flush,
    input  logic out_free,
    input  logic rep_valid,
    input  logic redir_valid,
    input  logic pred_valid,
    input  logic full,
    output src_e src
);

    always_comb begin
        src = SRC_NONE;
        if (!flush && out_free) begin
            if (rep_valid)                 src = SRC_REPLAY;
            else if (redir_valid && !full) src = SRC_REDIR;
            else if (pred_valid && !full)  src = SRC_PRED;
        end
    end

endmodule

// File: rtl/blkfetch_seq.sv
module blkfetch_seq
    import fseq_pkg::*;
#(
    parameter int AW       = 16,
    parameter int TW       = 8,
    parameter int DEPTH    = 4,
    parameter int LINE_LSB = 4,
    localparam int LW      = AW - LINE_LSB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pred_valid,
    input  logic [AW-1:0] pred_addr,
    output logic          pred_ready,
    input  logic          flush,
    input  logic [AW-1:0] flush_addr,
    output logic          req_valid,
    input  logic          req_ready,
    output logic [AW-1:0] req_addr,
    output logic [TW-1:0] req_tag,
    input  logic          req_hit,
    input  logic          fill_valid,
    input  logic [LW-1:0] fill_line,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [AW-1:0] out_addr,
    output logic [TW-1:0] out_tag
);

    typedef struct packed {
        logic          out_v;
        logic [AW-1:0] out_a;
        logic [TW-1:0] out_t;
        logic          redir_v;
        logic [AW-1:0] redir_a;
        logic [TW-1:0] seq;
    } st_t;

    st_t st_q, st_d;

    src_e          src;
    logic          out_free;
    logic          fire;
    logic          tab_full;
    logic          rep_valid;
    logic [AW-1:0] rep_addr;
    logic [TW-1:0] rep_tag;
    logic          alloc_en;
    logic          take_en;

    assign out_free = !st_q.out_v || out_ready;

    fseq_src_arb u_arb (
        .flush       (flush),
        .out_free    (out_free),
        .rep_valid   (rep_valid),
        .redir_valid (st_q.redir_v),
        .pred_valid  (pred_valid),
        .full        (tab_full),
        .src         (src)
    );

    always_comb begin
        case (src)
            SRC_REPLAY: begin req_addr = rep_addr;      req_tag = rep_tag;  end
            SRC_REDIR:  begin req_addr = st_q.redir_a;  req_tag = st_q.seq; end
            default:    begin req_addr = pred_addr;     req_tag = st_q.seq; end
        endcase
    end

    assign req_valid  = (src != SRC_NONE);
    assign fire       = req_valid && req_ready;
    assign pred_ready = fire && (src == SRC_PRED);
    assign alloc_en   = fire && !req_hit && (src != SRC_REPLAY);
    assign take_en    = fire && (src == SRC_REPLAY);

    fseq_pend_table #(
        .DEPTH    (DEPTH),
        .AW       (AW),
        .TW       (TW),
        .LINE_LSB (LINE_LSB)
    ) u_tab (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (flush),
        .alloc_en   (alloc_en),
        .alloc_addr (req_addr),
        .alloc_tag  (req_tag),
        .take_en    (take_en),
        .take_hit   (req_hit),
        .fill_en    (fill_valid),
        .fill_line  (fill_line),
        .rep_valid  (rep_valid),
        .rep_addr   (rep_addr),
        .rep_tag    (rep_tag),
        .full       (tab_full)
    );

    always_comb begin
        st_d = st_q;
        if (out_ready) st_d.out_v = 1'b0;
        if (fire && req_hit) begin
            st_d.out_v = 1'b1;
            st_d.out_a = req_addr;
            st_d.out_t = req_tag;
        end
        if (fire && (src != SRC_REPLAY)) st_d.seq = st_q.seq + 1'b1;
        if (fire && (src == SRC_REDIR))  st_d.redir_v = 1'b0;
        if (flush) begin
            st_d.out_v   = 1'b0;
            st_d.redir_v = 1'b1;
            st_d.redir_a = flush_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.out_v;
    assign out_addr  = st_q.out_a;
    assign out_tag   = st_q.out_t;

endmodule

// File: rtl/blkfetch_seq_chk.sv
module blkfetch_seq_chk #(
    parameter int AW = 16,
    parameter int TW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush,
    input logic          pred_valid,
    input logic [AW-1:0] pred_addr,
    input logic          pred_ready,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_addr,
    input logic          out_valid,
    input logic          out_ready,
    input logic [AW-1:0] out_addr,
    input logic [TW-1:0] out_tag,
    input logic          tab_full
);

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_addr) && $stable(out_tag))); // R3

    AST_NO_REQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !req_valid); // R3

    AST_PRED_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        pred_ready |-> (pred_valid && req_valid && req_ready && req_addr == pred_addr)); // R2

    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!req_valid && !pred_ready)); // R10

    AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid); // R10

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        tab_full |-> !pred_ready); // R9

endmodule

bind blkfetch_seq blkfetch_seq_chk #(.AW(AW), .TW(TW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .pred_valid (pred_valid),
    .pred_addr  (pred_addr),
    .pred_ready (pred_ready),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_addr   (out_addr),
    .out_tag    (out_tag),
    .tab_full   (tab_full)
);

// File: tb/sim_blkfetch_seq.sv
module sim_blkfetch_seq;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int TW = 8;
    localparam int LL = 4;
    localparam int NV = 28;

    typedef struct packed {
        logic          pv;
        logic [15:0]   pa;
        logic          rr;
        logic          hit;
        logic          fv;
        logic [15:0]   fa;
        logic          rv;
        logic [15:0]   ra;
        logic [7:0]    rt;
        logic          ov;
        logic [15:0]   oa;
        logic [7:0]    ot;
    } vec_t;

    // pv pa rr hit fv fa | rv ra rt | ov oa ot
    localparam vec_t VEC [NV] = '{
        '{1'b1,16'h0100,1'b1,1'b1,1'b0,16'h0000, 1'b1,16'h0100,8'd0,  1'b1,16'h0100,8'd0 },
        '{1'b1,16'h0110,1'b1,1'b0,1'b0,16'h0000, 1'b1,16'h0110,8'd1,  1'b0,16'h0000,8'd0 },
        '{1'b1,16'h0120,1'b1,1'b1,1'b0,16'h0000, 1'b1,16'h0120,8'd2,  1'b1,16'h0120,8'd2 },
        '{1'b1,16'h0130,1'b1,1'b1,1'b1,16'h0110, 1'b1,16'h0130,8'd3,  1'b1,16'h0130,8'd3 },
        '{1'b1,16'h0140,1'b1,1'b1,1'b0,16'h0000, 1'b1,16'h0110,8'd1,  1'b1,16'h0110,8'd1 },
        '{1'b1,16'h0140,1'b1,1'b1,1'b0,16'h0000, 1'b1,16'h0140,8'd4,  1'b1,16'h0140,8'd4 },
        '{1'b0,16'h0000,1'b1,1'b1,1'b0,16'h0000, 1'b0,16'h0000,8'd0,  1'b0,16'h0000,8'd0 },
        '{1'b1,16'h0150,1'b1,1'b0,1'b1,16'h0150, 1'b1,16'h0150,8'd5,  1'b0,16'h0000,8'd0 },
        '{1'b1,16'h0160,1'b1,1'b1,1'b0,16'h0000, 1'b1,16'h0150,8'd5,  1'b1,16'h0150,8'd5 },
        '{1'b1,16'h0160,1'b1,1'b1,1'b0,16'h0000, 1'b1,16'h0160,8'd6,  1'b1,16'h0160,8'd6 },
        '{1'b1,16'h0170,1'b1,1'b0,1'b0,16'h0000, 1'b1,16'h0170,8'd7,  1'b0,16'h0000,8'd0 },
        '{1'b0,16'h0000,1'b1,1'b1,1'b1,16'h0170, 1'b0,16'h0000,8'd0,  1'b0,16'h0000,8'd0 },
        '{1'b0,16'h0000,1'b1,1'b0,1'b0,16'h0000, 1'b1,16'h0170,8'd7,  1'b0,16'h0000,8'd0 },
        '{1'b0,16'h0000,1'b1,1'b1,1'b1,16'h0170, 1'b0,16'h0000,8'd0,  1'b0,16'h0000,8'd0 },
        '{1'b0,16'h0000,1'b1,1'b1,1'b0,16'h0000, 1'b1,16'h0170,8'd7,  1'b1,16'h0170,8'd7 },
        '{1'b1,16'h0200,1'b1,1'b0,1'b0,16'h0000, 1'b1,16'h0200,8'd8,  1'b0,16'h0000,8'd0 },
        '{1'b1,16'h0210,1'b1,1'b0,1'b0,16'h0000, 1'b1,16'h0210,8'd9,  1'b0,16'h0000,8'd0 },
        '{1'b1,16'h0220,1'b1,1'b0,1'b0,16'h0000, 1'b1,16'h0220,8'd10, 1'b0,16'h0000,8'd0 },
        '{1'b1,16'h0230,1'b1,1'b0,1'b0,16'h0000, 1'b1,16'h0230,8'd11, 1'b0,16'h0000,8'd0 },
        '{1'b1,16'h0240,1'b1,1'b1,1'b0,16'h0000, 1'b0,16'h0000,8'd0,  1'b0,16'h0000,8'd0 },
        '{1'b1,16'h0240,1'b1,1'b1,1'b1,16'h0210, 1'b0,16'h0000,8'd0,  1'b0,16'h0000,8'd0 },
        '{1'b1,16'h0240,1'b1,1'b1,1'b0,16'h0000, 1'b1,16'h0210,8'd9,  1'b1,16'h0210,8'd9 },
        '{1'b1,16'h0240,1'b1,1'b1,1'b0,16'h0000, 1'b1,16'h0240,8'd12, 1'b1,16'h0240,8'd12},
        '{1'b0,16'h0000,1'b0,1'b1,1'b1,16'h0230, 1'b0,16'h0000,8'd0,  1'b0,16'h0000,8'd0 },
        '{1'b0,16'h0000,1'b0,1'b1,1'b1,16'h0200, 1'b1,16'h0230,8'd11, 1'b0,16'h0000,8'd0 },
        '{1'b0,16'h0000,1'b1,1'b1,1'b0,16'h0000, 1'b1,16'h0200,8'd8,  1'b1,16'h0200,8'd8 },
        '{1'b0,16'h0000,1'b1,1'b1,1'b0,16'h0000, 1'b1,16'h0230,8'd11, 1'b1,16'h0230,8'd11},
        '{1'b0,16'h0000,1'b1,1'b1,1'b0,16'h0000, 1'b0,16'h0000,8'd0,  1'b0,16'h0000,8'd0 }
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pred_valid = 1'b0;
    logic [AW-1:0] pred_addr = '0;
    logic          pred_ready;
    logic          flush = 1'b0;
    logic [AW-1:0] flush_addr = '0;
    logic          req_valid;
    logic          req_ready = 1'b0;
    logic [AW-1:0] req_addr;
    logic [TW-1:0] req_tag;
    logic          req_hit = 1'b0;
    logic          fill_valid = 1'b0;
    logic [AW-LL-1:0] fill_line = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [AW-1:0] out_addr;
    logic [TW-1:0] out_tag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    blkfetch_seq #(.AW(AW), .TW(TW), .DEPTH(4), .LINE_LSB(LL)) u0 (
        .clk(clk), .rst_n(rst_n),
        .pred_valid(pred_valid), .pred_addr(pred_addr), .pred_ready(pred_ready),
        .flush(flush), .flush_addr(flush_addr),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_tag(req_tag), .req_hit(req_hit),
        .fill_valid(fill_valid), .fill_line(fill_line),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .out_tag(out_tag)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string row_req(input int i);
        if (i < 3)       return "R4";
        else if (i < 6)  return "R5";
        else if (i < 7)  return "R2";
        else if (i < 10) return "R6";
        else if (i < 15) return "R7";
        else if (i < 23) return "R9";
        else if (i < 25) return "R11";
        else             return "R8";
    endfunction

    task automatic drive(input logic pv, input logic [15:0] pa, input logic rr,
                         input logic hit, input logic fv, input logic [15:0] fa,
                         input logic ordy, input logic fl, input logic [15:0] fla);
        pred_valid = pv;  pred_addr = pa;  req_ready = rr;  req_hit = hit;
        fill_valid = fv;  fill_line = fa[15:LL];
        out_ready  = ordy; flush = fl; flush_addr = fla;
    endtask

    task automatic step_out(input string req, input logic ov,
                            input logic [15:0] oa, input logic [7:0] ot);
        @(negedge clk);
        check(req, "out_valid", 32'(out_valid), 32'(ov));
        if (ov) begin
            check(req, "out_addr", 32'(out_addr), 32'(oa));
            check(req, "out_tag",  32'(out_tag),  32'(ot));
        end
    endtask

    task automatic see_req(input string req, input logic rv,
                           input logic [15:0] ra, input logic [7:0] rt, input logic prdy);
        #1;
        check(req, "req_valid", 32'(req_valid), 32'(rv));
        if (rv) begin
            check(req, "req_addr", 32'(req_addr), 32'(ra));
            check(req, "req_tag",  32'(req_tag),  32'(rt));
        end
        check(req, "pred_ready", 32'(pred_ready), 32'(prdy));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state with no prediction offered
        #1;
        check("R1", "out_valid", 32'(out_valid), 32'd0);
        check("R1", "req_valid", 32'(req_valid), 32'd0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].pv, VEC[i].pa, VEC[i].rr, VEC[i].hit, VEC[i].fv, VEC[i].fa,
                  1'b1, 1'b0, 16'h0);
            see_req(row_req(i), VEC[i].rv, VEC[i].ra, VEC[i].rt,
                    VEC[i].pv && VEC[i].rr && VEC[i].rv && (VEC[i].ra == VEC[i].pa));
            step_out(row_req(i), VEC[i].ov, VEC[i].oa, VEC[i].ot);
        end

        // R3: output held under back-pressure, no request while blocked
        drive(1'b1, 16'h0300, 1'b1, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0);
        see_req("R3", 1'b1, 16'h0300, 8'd13, 1'b1);
        step_out("R3", 1'b1, 16'h0300, 8'd13);
        drive(1'b1, 16'h0310, 1'b1, 1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 16'h0);
        see_req("R3", 1'b0, 16'h0, 8'd0, 1'b0);
        step_out("R3", 1'b1, 16'h0300, 8'd13);
        drive(1'b1, 16'h0310, 1'b1, 1'b1, 1'b0, 16'h0, 1'b1, 1'b0, 16'h0);
        see_req("R3", 1'b1, 16'h0310, 8'd14, 1'b1);
        step_out("R3", 1'b1, 16'h0310, 8'd14);

        // R10: flush with 0x0220 still parked, redirect to 0x0800
        drive(1'b1, 16'h0900, 1'b1, 1'b1, 1'b0, 16'h0, 1'b0, 1'b1, 16'h0800);
        see_req("R10", 1'b0, 16'h0, 8'd0, 1'b0);
        step_out("R10", 1'b0, 16'h0, 8'd0);
        drive(1'b1, 16'h0900, 1'b1, 1'b1, 1'b0, 16'h0, 1'b1, 1'b0, 16'h0);
        see_req("R10", 1'b1, 16'h0800, 8'd15, 1'b0);
        step_out("R10", 1'b1, 16'h0800, 8'd15);
        see_req("R10", 1'b1, 16'h0900, 8'd16, 1'b1);
        step_out("R10", 1'b1, 16'h0900, 8'd16);
        drive(1'b0, 16'h0, 1'b1, 1'b1, 1'b1, 16'h0220, 1'b1, 1'b0, 16'h0);
        see_req("R10", 1'b0, 16'h0, 8'd0, 1'b0);
        step_out("R10", 1'b0, 16'h0, 8'd0);
        drive(1'b0, 16'h0, 1'b1, 1'b1, 1'b0, 16'h0, 1'b1, 1'b0, 16'h0);
        see_req("R10", 1'b0, 16'h0, 8'd0, 1'b0);
        step_out("R10", 1'b0, 16'h0, 8'd0);

        // R1: reset again drops output and parked state
        drive(1'b1, 16'h0a00, 1'b1, 1'b0, 1'b0, 16'h0, 1'b1, 1'b0, 16'h0);
        @(negedge clk);
        rst_n = 1'b0;
        drive(1'b0, 16'h0, 1'b1, 1'b1, 1'b1, 16'h0a00, 1'b1, 1'b0, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, 16'h0, 1'b1, 1'b1, 1'b0, 16'h0, 1'b1, 1'b0, 16'h0);
        see_req("R1", 1'b0, 16'h0, 8'd0, 1'b0);
        check("R1", "out_valid", 32'(out_valid), 32'd0);
        drive(1'b1, 16'h0b00, 1'b1, 1'b1, 1'b0, 16'h0, 1'b1, 1'b0, 16'h0);
        see_req("R1", 1'b1, 16'h0b00, 8'd0, 1'b1);
        step_out("R1", 1'b1, 16'h0b00, 8'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule